// File: doc/BRIEF.md
# Addressable Latch and Demultiplexer

This block holds eight single-bit storage cells that are loaded one at a time from a shared data line. A 3-bit address picks the cell, and a serial bit stream can be assembled into a parallel pattern over successive clocks. Every output is active-low: a stored 1 pulls its output low, and a stored 0 leaves it high.

Two active-low controls, a clear and an enable, select one of four modes:

| clr_n | en_n | Mode |
|-------|------|------|
| 1 | 0 | write |
| 1 | 1 | hold |
| 0 | 0 | decode |
| 0 | 1 | clear |

In decode mode the same address and data steer a single bit onto one output, so the block works as a 3-to-8 demultiplexer. Clear mode forces every output high. Both decode and clear empty the storage at the next rising edge. State changes only on the rising clock edge. The decode and clear output overrides are combinational.

Top module: `addr_latch_demux`

## Requirements
- R1: Address value k (0 to 7) selects storage cell k, and cell k drives output bit q_n[k].
- R2: In write mode (clr_n=1, en_n=0), the rising clock edge loads din into the addressed cell. After that edge, q_n[addr] equals the inverse of din and every other output bit keeps its value.
- R3: In hold mode (clr_n=1, en_n=1), q_n keeps its previous value whatever din and addr do.
- R4: In decode mode (clr_n=0, en_n=0), q_n[addr] equals the inverse of din combinationally, in the same cycle, and every other output bit is 1.
- R5: In clear mode (clr_n=0, en_n=1), every bit of q_n is 1 regardless of addr and din.
- R6: The asynchronous active-low reset rst_n empties every cell, so all outputs read 1 while it is asserted and after it is released.
- R7: A rising edge in clear or decode mode empties every cell. In a later hold cycle all outputs read 1, except cells written after that edge.
- R8: While en_n is high with clr_n high, changes on addr and din cause no write to any cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Data bit for the selected cell or output |
| addr | input | 3 | Cell or output select |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q_n | output | 8 | Active-low outputs, bit k driven by cell k |

## Verification
On every cycle, the assertions check the following:
- In clear mode all outputs are high.
- In decode mode at most one output is low, and that output follows the inverted data.
- Consecutive hold cycles leave the outputs stable.
- A write changes at most one output bit: the addressed one.
- Clear and decode leave the outputs all high when hold mode follows.

Only the bench's scenarios can show the following:
- The exact bit patterns built up over long write sequences.
- That each address maps to its own output position.
- That an asynchronous reset in the middle of a run empties the cells.
- That sweeping the address with the enable high leaves the stored pattern untouched.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR  = 2'd3
    } mode_e;

    function automatic mode_e mode_from_pins(input logic clr_n, input logic en_n);
        mode_e m;
        unique case ({clr_n, en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DECODE;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alt_mode_decode.sv
module alt_mode_decode
    import addr_latch_pkg::*;
(
    input  logic  clr_n,
    input  logic  en_n,
    output mode_e mode
);
    always_comb begin
        mode = mode_from_pins(clr_n, en_n);
    end
endmodule

// File: rtl/alt_addr_decode.sv
module alt_addr_decode #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    for (genvar k = 0; k < N; k++) begin : g_sel
        assign sel[k] = (addr == AW'(k));
    end
endmodule

// File: rtl/alt_cell_store.sv
module alt_cell_store
    import addr_latch_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic [N-1:0] sel,
    input  logic         din,
    output logic [N-1:0] cells
);
    typedef struct packed {
        logic [N-1:0] cells;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_WRITE: begin
                for (int k = 0; k < N; k++) begin
                    if (sel[k]) st_d.cells[k] = din;
                end
            end
            MODE_DECODE,
            MODE_CLEAR: st_d.cells = '0;
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cells = st_q.cells;
endmodule

// File: rtl/alt_out_stage.sv
module alt_out_stage
    import addr_latch_pkg::*;
#(
    parameter int N = 8
) (
    input  mode_e        mode,
    input  logic [N-1:0] sel,
    input  logic         din,
    input  logic [N-1:0] cells,
    output logic [N-1:0] q_n
);
    for (genvar k = 0; k < N; k++) begin : g_out
        always_comb begin
            unique case (mode)
                MODE_CLEAR:  q_n[k] = 1'b1;
                MODE_DECODE: q_n[k] = sel[k] ? ~din : 1'b1;
                default:     q_n[k] = ~cells[k];
            endcase
        end
    end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
    import addr_latch_pkg::*;
#(
    parameter  int NUM_CELLS = 8,
    localparam int ADDR_W    = $clog2(NUM_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 en_n,
    input  logic                 clr_n,
    output logic [NUM_CELLS-1:0] q_n
);
    mode_e                mode;
    logic [NUM_CELLS-1:0] sel;
    logic [NUM_CELLS-1:0] cells;

    alt_mode_decode u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    alt_addr_decode #(.N(NUM_CELLS), .AW(ADDR_W)) u_adec (
        .addr (addr),
        .sel  (sel)
    );

    alt_cell_store #(.N(NUM_CELLS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .sel   (sel),
        .din   (din),
        .cells (cells)
    );

    alt_out_stage #(.N(NUM_CELLS)) u_out (
        .mode  (mode),
        .sel   (sel),
        .din   (din),
        .cells (cells),
        .q_n   (q_n)
    );
endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          din,
    input logic [AW-1:0] addr,
    input logic          en_n,
    input logic          clr_n,
    input logic [N-1:0]  q_n
);
    // R5: clear mode drives every output high
    a_r5_clear_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && en_n) |-> (q_n == '1));

    // R4: decode mode shows at most one low output
    a_r4_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |-> ($countones(~q_n) <= 1));

    // R4: decode mode puts the inverted data on the addressed output
    a_r4_decode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |-> (q_n[addr] == !din));

    // R3: consecutive hold cycles keep the outputs stable
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n && $past(clr_n) && $past(en_n)) |-> $stable(q_n));

    // R2: a write followed by hold shows the written bit on the addressed output
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_n) && !$past(en_n) && clr_n && en_n) |-> (q_n[$past(addr)] == !$past(din)));

    // R2: a write followed by hold changes at most one output bit
    a_r2_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_n) && !$past(en_n) && clr_n && en_n) |-> ($countones(q_n ^ $past(q_n)) <= 1));

    // R7: clear or decode followed by hold leaves all outputs high
    a_r7_flush_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_n) && clr_n && en_n) |-> (q_n == '1));
endmodule

bind addr_latch_demux addr_latch_demux_chk #(.N(NUM_CELLS), .AW(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .addr  (addr),
    .en_n  (en_n),
    .clr_n (clr_n),
    .q_n   (q_n)
);

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [2:0] addr = '0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q_n;

    int checks = 0;
    int errors = 0;
    int store[8];

    always #10 clk = ~clk;

    addr_latch_demux dut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .addr  (addr),
        .en_n  (en_n),
        .clr_n (clr_n),
        .q_n   (q_n)
    );

    function automatic logic [7:0] expected();
        logic [7:0] e;
        for (int k = 0; k < 8; k++) begin
            if (!clr_n && en_n)       e[k] = 1'b1;
            else if (!clr_n && !en_n) e[k] = (int'(addr) == k) ? ~din : 1'b1;
            else                      e[k] = (store[k] != 0) ? 1'b0 : 1'b1;
        end
        return e;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] e;
        e = expected();
        checks++;
        if (q_n !== e) begin
            errors++;
            $display("FAIL %s: q_n=%b expected=%b (clr_n=%b en_n=%b addr=%0d din=%b)",
                     tag, q_n, e, clr_n, en_n, addr, din);
        end
    endtask

    task automatic step(input logic c, input logic e, input int a, input logic d, input string tag);
        @(negedge clk);
        clr_n = c; en_n = e; addr = 3'(a); din = d;
        #2;
        compare(tag);
        @(posedge clk);
        #1;
        if (c && !e) store[a] = d ? 1 : 0;
        else if (!c) begin
            for (int k = 0; k < 8; k++) store[k] = 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) store[k] = 0;
        #5;
        compare("R6 reset asserted");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        compare("R6 after reset release");

        // R1: a single write to address 5 lands on bit 5 only
        step(1, 0, 5, 1, "R1 write addr5");
        step(1, 1, 0, 0, "R1 addr5 maps to bit5");
        checks++;
        if (q_n !== 8'b1101_1111) begin
            errors++;
            $display("FAIL R1: q_n=%b expected=%b", q_n, 8'b1101_1111);
        end

        // R2: write every address with alternating data, hold in between
        for (int a = 0; a < 8; a++) begin
            step(1, 0, a, a[0], "R2 write");
            step(1, 1, 7 - a, ~a[0], "R2 hold after write");
        end
        for (int a = 0; a < 8; a++) step(1, 0, a, 1, "R2 write ones");
        step(1, 1, 0, 0, "R2 all written");
        step(1, 0, 3, 0, "R2 clear one cell by write");
        step(1, 1, 3, 1, "R2 single bit cleared");

        // R3 and R8: hold with sweeping address and data
        for (int a = 0; a < 8; a++) begin
            step(1, 1, a, 1, "R8 addr sweep no write");
            step(1, 1, a, 0, "R3 hold ignores inputs");
        end

        // R4: decode mode, all addresses and both data values
        for (int a = 0; a < 8; a++) begin
            step(0, 0, a, 1, "R4 decode d1");
            step(0, 0, a, 0, "R4 decode d0");
        end
        step(1, 1, 2, 1, "R7 hold after decode");

        // R5 and R7: build a pattern, then clear
        step(1, 0, 1, 1, "R2 pattern");
        step(1, 0, 6, 1, "R2 pattern");
        for (int a = 0; a < 8; a++) step(0, 1, a, a[1], "R5 clear mode");
        step(1, 1, 6, 1, "R7 hold after clear");
        step(1, 0, 4, 1, "R7 write after clear");
        step(1, 1, 0, 0, "R7 only later write low");

        // R6: asynchronous reset in mid-run
        step(1, 0, 0, 1, "R2 before reset");
        step(1, 1, 0, 0, "R2 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        for (int k = 0; k < 8; k++) store[k] = 0;
        compare("R6 async reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 1, 5, 1, "R6 after mid-run reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule